// File: doc/BRIEF.md
# Elevator-Steering Route Computation Stage

This block is the route-computation stage for one input port of a router in a stacked mesh network where only some routers have a vertical link. These routers are called elevators. From the head flit's destination coordinates and this router's own coordinates, it picks exactly one of seven output ports: local, north, east, south, west, up or down. Traffic that stays on its own layer follows dimension-order routing, with X resolved before Y. Traffic bound for another layer goes vertically when this router is an elevator. Otherwise it is steered toward an elevator by a 4-bit direction vector. Two such vectors are supplied, one for upward traffic and one for downward traffic. These 8 bits are the only elevator information the router needs, and no addresses are stored.

The arrival side of each instance is fixed by a parameter, so every input port gets its own copy of the logic. With the turn-fix option enabled, a packet that entered on a north or south input while searching for an elevator keeps travelling along Y in the same direction. The result is latched when a head flit is present and held for the body and tail flits that follow. A virtual-channel bit comes with it: upward-bound traffic uses channel 0 and downward-bound traffic uses channel 1. A misconfiguration flag is raised when the selected vector is empty.

Top module: `vroute_stage`

## Requirements
- R1: Port encoding is one-hot in `route_port`: bit 0 local, bit 1 north, bit 2 east, bit 3 south, bit 4 west, bit 5 up, bit 6 down. Reset clears `route_port`, `route_vc` and `route_err` to zero. One cycle after a head flit, exactly one bit of `route_port` is set.
- R2: While `head_valid` is low, `route_port`, `route_vc` and `route_err` keep their previous values, whatever the other inputs do.
- R3: When `dst_z` equals `cur_z`, routing is dimension-order. A larger `dst_x` selects east and a smaller one selects west. If the X coordinates are equal, a larger `dst_y` selects north and a smaller one selects south. If all coordinates match, the local port is selected.
- R4: When the layers differ and `is_elev` is high, the up port is chosen if `dst_z` > `cur_z`, and the down port otherwise.
- R5: For a non-elevator router on another layer, `up_vec` is used when `dst_z` > `cur_z` and `dn_vec` when `dst_z` < `cur_z`. In both vectors, bit 3 means north, bit 2 east, bit 1 south and bit 0 west.
- R6: The selected vector is decoded with X first. The east bit wins over all others, then west, then north, then south.
- R7: With `TURN_FIX` set, a non-elevator router on another layer whose `ARRIVE_DIR` is north (code 1) always routes south. One whose `ARRIVE_DIR` is south (code 3) always routes north. This holds whatever the vector contains, and `route_err` stays low.
- R8: `route_vc` is 1 when `dst_z` < `cur_z`, and 0 otherwise.
- R9: If the selected vector is all zero and R4 and R7 do not apply, the local port is chosen and `route_err` is set. In every other case `route_err` is 0.
- R10: A change to `up_vec` or `dn_vec` takes effect at the next head flit, with no reset and no other action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_valid | input | 1 | A head flit is present; latch a new route |
| cur_x | input | CW | This router's X coordinate |
| cur_y | input | CW | This router's Y coordinate |
| cur_z | input | ZW | This router's layer |
| dst_x | input | CW | Destination X coordinate |
| dst_y | input | CW | Destination Y coordinate |
| dst_z | input | ZW | Destination layer |
| is_elev | input | 1 | This router has a vertical link |
| up_vec | input | 4 | Direction toward the elevator for upward traffic (N,E,S,W) |
| dn_vec | input | 4 | Direction toward the elevator for downward traffic (N,E,S,W) |
| route_port | output | 7 | Latched one-hot output port |
| route_vc | output | 1 | Latched virtual channel |
| route_err | output | 1 | Latched empty-vector misconfiguration flag |

## Verification
Two functions can meet in the same cycle. The first is a head flit that latches a new route. The second is a rewrite of the elevator vectors that a new head flit must see (R10) but that a body cycle must ignore (R2). The bench provokes this by changing the vectors and the coordinates on body cycles and then again on the next head cycle. It expects the held value first and the newly decoded port after it. It also sets conflicting vector bits together with a turn-fix arrival, so the priority order and the forced Y direction are judged against the same stimulus on three instances with different arrival parameters.

// File: rtl/vroute_pkg.sv
package vroute_pkg;

  // output port indices (one-hot bit positions)
  localparam int PI_LOCAL = 0;
  localparam int PI_NORTH = 1;
  localparam int PI_EAST  = 2;
  localparam int PI_SOUTH = 3;
  localparam int PI_WEST  = 4;
  localparam int PI_UP    = 5;
  localparam int PI_DOWN  = 6;
  localparam int NPORTS   = 7;

  // arrival side codes for the per-instance parameter
  localparam int ARR_LOCAL = 0;
  localparam int ARR_NORTH = 1;
  localparam int ARR_EAST  = 2;
  localparam int ARR_SOUTH = 3;
  localparam int ARR_WEST  = 4;

  typedef logic [NPORTS-1:0] port_oh_t;

  // direction set, MSB first: north, east, south, west
  typedef struct packed {
    logic n;
    logic e;
    logic s;
    logic w;
  } dir4_t;

  function automatic port_oh_t oh_of(input int idx);
    port_oh_t r;
    r = '0;
    r[idx] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/vroute_rst_sync.sv
module vroute_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/vroute_cmp.sv
module vroute_cmp
  import vroute_pkg::*;
#(
  parameter int CW = 4,
  parameter int ZW = 2
) (
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [ZW-1:0] cur_z,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [ZW-1:0] dst_z,
  output dir4_t         plane_dir,
  output logic          z_up,
  output logic          z_dn
);

  always_comb begin
    plane_dir.e = (dst_x > cur_x);
    plane_dir.w = (dst_x < cur_x);
    plane_dir.n = (dst_y > cur_y);
    plane_dir.s = (dst_y < cur_y);
    z_up        = (dst_z > cur_z);
    z_dn        = (dst_z < cur_z);
  end

endmodule

// File: rtl/vroute_steer.sv
module vroute_steer
  import vroute_pkg::*;
(
  input  dir4_t    dir,
  output port_oh_t port,
  output logic     none
);

  // X before Y; east over west, north over south
  always_comb begin
    port = '0;
    none = 1'b0;
    if (dir.e)      port[PI_EAST]  = 1'b1;
    else if (dir.w) port[PI_WEST]  = 1'b1;
    else if (dir.n) port[PI_NORTH] = 1'b1;
    else if (dir.s) port[PI_SOUTH] = 1'b1;
    else            none           = 1'b1;
  end

endmodule

// File: rtl/vroute_core.sv
module vroute_core
  import vroute_pkg::*;
#(
  parameter int CW         = 4,
  parameter int ZW         = 2,
  parameter int ARRIVE_DIR = ARR_LOCAL,
  parameter bit TURN_FIX   = 1'b1
) (
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [ZW-1:0] cur_z,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [ZW-1:0] dst_z,
  input  logic          is_elev,
  input  dir4_t         up_vec,
  input  dir4_t         dn_vec,
  output port_oh_t      port_nxt,
  output logic          vc_nxt,
  output logic          err_nxt
);

  dir4_t    plane_dir;
  dir4_t    elev_vec;
  logic     z_up;
  logic     z_dn;
  port_oh_t plane_oh;
  port_oh_t elev_oh;
  logic     plane_none;
  logic     elev_none;
  logic     forced;
  port_oh_t forced_oh;

  vroute_cmp #(.CW(CW), .ZW(ZW)) u_cmp (
    .cur_x     (cur_x),
    .cur_y     (cur_y),
    .cur_z     (cur_z),
    .dst_x     (dst_x),
    .dst_y     (dst_y),
    .dst_z     (dst_z),
    .plane_dir (plane_dir),
    .z_up      (z_up),
    .z_dn      (z_dn)
  );

  assign elev_vec = z_up ? up_vec : dn_vec;

  vroute_steer u_plane (
    .dir  (plane_dir),
    .port (plane_oh),
    .none (plane_none)
  );

  vroute_steer u_elev (
    .dir  (elev_vec),
    .port (elev_oh),
    .none (elev_none)
  );

  // per-port variant: keep the Y direction of travel when seeking an elevator
  generate
    if (TURN_FIX && (ARRIVE_DIR == ARR_NORTH)) begin : g_fix_n
      assign forced    = 1'b1;
      assign forced_oh = oh_of(PI_SOUTH);
    end else if (TURN_FIX && (ARRIVE_DIR == ARR_SOUTH)) begin : g_fix_s
      assign forced    = 1'b1;
      assign forced_oh = oh_of(PI_NORTH);
    end else begin : g_nofix
      assign forced    = 1'b0;
      assign forced_oh = '0;
    end
  endgenerate

  always_comb begin
    port_nxt = '0;
    err_nxt  = 1'b0;
    vc_nxt   = z_dn;
    if (!z_up && !z_dn) begin
      port_nxt = plane_none ? oh_of(PI_LOCAL) : plane_oh;
    end else if (is_elev) begin
      port_nxt = z_up ? oh_of(PI_UP) : oh_of(PI_DOWN);
    end else if (forced) begin
      port_nxt = forced_oh;
    end else if (elev_none) begin
      port_nxt = oh_of(PI_LOCAL);
      err_nxt  = 1'b1;
    end else begin
      port_nxt = elev_oh;
    end
  end

endmodule

// File: rtl/vroute_stage.sv
module vroute_stage
  import vroute_pkg::*;
#(
  parameter int CW         = 4,
  parameter int ZW         = 2,
  parameter int ARRIVE_DIR = ARR_LOCAL,
  parameter bit TURN_FIX   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_valid,
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [ZW-1:0] cur_z,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [ZW-1:0] dst_z,
  input  logic          is_elev,
  input  logic [3:0]    up_vec,
  input  logic [3:0]    dn_vec,
  output logic [6:0]    route_port,
  output logic          route_vc,
  output logic          route_err
);

  logic     rst_q_n;
  port_oh_t port_nxt;
  logic     vc_nxt;
  logic     err_nxt;
  port_oh_t port_d, port_q;
  logic     vc_d, vc_q;
  logic     err_d, err_q;

  vroute_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  vroute_core #(
    .CW(CW), .ZW(ZW), .ARRIVE_DIR(ARRIVE_DIR), .TURN_FIX(TURN_FIX)
  ) u_core (
    .cur_x    (cur_x),
    .cur_y    (cur_y),
    .cur_z    (cur_z),
    .dst_x    (dst_x),
    .dst_y    (dst_y),
    .dst_z    (dst_z),
    .is_elev  (is_elev),
    .up_vec   (dir4_t'(up_vec)),
    .dn_vec   (dir4_t'(dn_vec)),
    .port_nxt (port_nxt),
    .vc_nxt   (vc_nxt),
    .err_nxt  (err_nxt)
  );

  // next state: latch on head flit only
  always_comb begin
    port_d = port_q;
    vc_d   = vc_q;
    err_d  = err_q;
    if (head_valid) begin
      port_d = port_nxt;
      vc_d   = vc_nxt;
      err_d  = err_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      port_q <= '0;
      vc_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      port_q <= port_d;
      vc_q   <= vc_d;
      err_q  <= err_d;
    end
  end

  assign route_port = port_q;
  assign route_vc   = vc_q;
  assign route_err  = err_q;

endmodule

// File: rtl/vroute_chk.sv
module vroute_chk #(
  parameter int ZW         = 2,
  parameter int ARRIVE_DIR = 0,
  parameter bit TURN_FIX   = 1'b1
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          head_valid,
  input logic [ZW-1:0] cur_z,
  input logic [ZW-1:0] dst_z,
  input logic          is_elev,
  input logic [6:0]    route_port,
  input logic          route_vc,
  input logic          route_err
);

  AST_PORT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(route_port)); // R1

  AST_HEAD_GIVES_PORT: assert property (@(posedge clk) disable iff (!rst_q_n)
    head_valid |=> $countones(route_port) == 1); // R1

  AST_BODY_HOLDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    !head_valid |=> $stable(route_port) && $stable(route_vc) && $stable(route_err)); // R2

  AST_ELEV_VERTICAL: assert property (@(posedge clk) disable iff (!rst_q_n)
    head_valid && is_elev && (dst_z != cur_z) |=> (route_port[5] == $past(dst_z > cur_z)) && (route_port[6] == $past(dst_z < cur_z))); // R4

  AST_VC_BY_LAYER: assert property (@(posedge clk) disable iff (!rst_q_n)
    head_valid |=> route_vc == $past(dst_z < cur_z)); // R8

  AST_ERR_TO_LOCAL: assert property (@(posedge clk) disable iff (!rst_q_n)
    route_err |-> route_port == 7'b0000001); // R9

  AST_SAME_LAYER_NO_ERR: assert property (@(posedge clk) disable iff (!rst_q_n)
    head_valid && (dst_z == cur_z) |=> !route_err && !route_port[5] && !route_port[6]); // R3

  generate
    if (TURN_FIX && (ARRIVE_DIR == 1)) begin : g_chk_n
      AST_TURNFIX_SOUTH: assert property (@(posedge clk) disable iff (!rst_q_n)
        head_valid && !is_elev && (dst_z != cur_z) |=> route_port[3] && !route_err); // R7
    end else if (TURN_FIX && (ARRIVE_DIR == 3)) begin : g_chk_s
      AST_TURNFIX_NORTH: assert property (@(posedge clk) disable iff (!rst_q_n)
        head_valid && !is_elev && (dst_z != cur_z) |=> route_port[1] && !route_err); // R7
    end
  endgenerate

endmodule

bind vroute_stage vroute_chk #(
  .ZW(ZW), .ARRIVE_DIR(ARRIVE_DIR), .TURN_FIX(TURN_FIX)
) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .head_valid (head_valid),
  .cur_z      (cur_z),
  .dst_z      (dst_z),
  .is_elev    (is_elev),
  .route_port (route_port),
  .route_vc   (route_vc),
  .route_err  (route_err)
);

// File: tb/tb_vroute_stage.sv
module tb_vroute_stage;

  logic       clk;
  logic       rst_n;
  logic       head;
  logic [3:0] cx, cy, dx, dy;
  logic [1:0] cz, dz;
  logic       el;
  logic [3:0] uv, dv;

  logic [6:0] p0, p1, p2;
  logic       v0, v1, v2;
  logic       e0, e1, e2;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [6:0] ep [3];
  logic       ev [3];
  logic       ee [3];
  string      et [3];

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // arrival north with turn fix
  vroute_stage #(.CW(4), .ZW(2), .ARRIVE_DIR(1), .TURN_FIX(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .head_valid(head),
    .cur_x(cx), .cur_y(cy), .cur_z(cz), .dst_x(dx), .dst_y(dy), .dst_z(dz),
    .is_elev(el), .up_vec(uv), .dn_vec(dv),
    .route_port(p0), .route_vc(v0), .route_err(e0));

  // arrival south with turn fix
  vroute_stage #(.CW(4), .ZW(2), .ARRIVE_DIR(3), .TURN_FIX(1'b1)) dut_s (
    .clk(clk), .rst_n(rst_n), .head_valid(head),
    .cur_x(cx), .cur_y(cy), .cur_z(cz), .dst_x(dx), .dst_y(dy), .dst_z(dz),
    .is_elev(el), .up_vec(uv), .dn_vec(dv),
    .route_port(p1), .route_vc(v1), .route_err(e1));

  // arrival north, turn fix disabled: follows the vector
  vroute_stage #(.CW(4), .ZW(2), .ARRIVE_DIR(1), .TURN_FIX(1'b0)) dut_p (
    .clk(clk), .rst_n(rst_n), .head_valid(head),
    .cur_x(cx), .cur_y(cy), .cur_z(cz), .dst_x(dx), .dst_y(dy), .dst_z(dz),
    .is_elev(el), .up_vec(uv), .dn_vec(dv),
    .route_port(p2), .route_vc(v2), .route_err(e2));

  // behavioural reference, ports: 0 L,1 N,2 E,3 S,4 W,5 U,6 D
  task automatic ref_route(input int arr, input bit fix,
                           output logic [6:0] p, output logic vc,
                           output logic er, output string tag);
    int xs, xd, ys, yd, zs, zd, pick;
    logic [3:0] v;
    xs = int'(cx); xd = int'(dx); ys = int'(cy); yd = int'(dy);
    zs = int'(cz); zd = int'(dz);
    vc = (zd < zs);
    er = 1'b0;
    pick = 0;
    if (zd == zs) begin
      tag = "R3";
      if (xd > xs) pick = 2;
      else if (xd < xs) pick = 4;
      else if (yd > ys) pick = 1;
      else if (yd < ys) pick = 3;
      else pick = 0;
    end else if (el) begin
      tag = "R4";
      pick = (zd > zs) ? 5 : 6;
    end else if (fix && arr == 1) begin
      tag = "R7"; pick = 3;
    end else if (fix && arr == 3) begin
      tag = "R7"; pick = 1;
    end else begin
      v = (zd > zs) ? uv : dv;
      tag = "R6";
      if (v[2]) pick = 2;
      else if (v[0]) pick = 4;
      else if (v[3]) pick = 1;
      else if (v[1]) pick = 3;
      else begin pick = 0; er = 1'b1; tag = "R9"; end
    end
    p = 7'd1 << pick;
  endtask

  task automatic cmp1(input int i, input logic [6:0] ap, input logic av, input logic ae);
    n_chk++;
    if (ap !== ep[i] || av !== ev[i] || ae !== ee[i]) begin
      n_fail++;
      $display("FAIL %s inst%0d: got port=%b vc=%b err=%b expected port=%b vc=%b err=%b",
               et[i], i, ap, av, ae, ep[i], ev[i], ee[i]);
    end
  endtask

  task automatic check_all();
    cmp1(0, p0, v0, e0);
    cmp1(1, p1, v1, e1);
    cmp1(2, p2, v2, e2);
  endtask

  // one cycle: check the result of the previous cycle, then apply new stimulus
  task automatic step(input logic h, input logic [3:0] ax, ay, bx, by,
                      input logic [1:0] az, bz, input logic e,
                      input logic [3:0] u, d, input string ovr);
    logic [6:0] tp; logic tv, te; string tt;
    @(negedge clk);
    check_all();
    head = h; cx = ax; cy = ay; dx = bx; dy = by; cz = az; dz = bz;
    el = e; uv = u; dv = d;
    for (int i = 0; i < 3; i++) begin
      if (h) begin
        ref_route((i == 1) ? 3 : 1, (i != 2), tp, tv, te, tt);
        ep[i] = tp; ev[i] = tv; ee[i] = te;
        et[i] = (ovr != "") ? ovr : tt;
      end else begin
        et[i] = "R2";
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    head = 0; cx = 0; cy = 0; dx = 0; dy = 0; cz = 0; dz = 0; el = 0; uv = 0; dv = 0;
    for (int i = 0; i < 3; i++) begin
      ep[i] = '0; ev[i] = 0; ee[i] = 0; et[i] = "R1";
    end
    repeat (3) @(negedge clk);
    check_all();                                      // R1 reset state
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 planar, X before Y
    step(1, 4'd5, 4'd5, 4'd9, 4'd1, 2'd1, 2'd1, 0, 4'h0, 4'h0, "");
    step(1, 4'd5, 4'd5, 4'd2, 4'd9, 2'd1, 2'd1, 0, 4'h0, 4'h0, "");
    step(1, 4'd5, 4'd5, 4'd5, 4'd9, 2'd1, 2'd1, 1, 4'h0, 4'h0, "");
    step(1, 4'd5, 4'd5, 4'd5, 4'd0, 2'd1, 2'd1, 0, 4'h0, 4'h0, "");
    step(1, 4'd5, 4'd5, 4'd5, 4'd5, 2'd1, 2'd1, 0, 4'h0, 4'h0, "");
    // R4 elevator router
    step(1, 4'd3, 4'd3, 4'd0, 4'd0, 2'd1, 2'd3, 1, 4'h0, 4'h0, "");
    step(1, 4'd3, 4'd3, 4'd0, 4'd0, 2'd2, 2'd0, 1, 4'h0, 4'h0, "R8");
    // R5 vector choice by layer, R6 priority
    step(1, 4'd3, 4'd3, 4'd9, 4'd9, 2'd0, 2'd2, 0, 4'b0001, 4'b0100, "R5");
    step(1, 4'd3, 4'd3, 4'd9, 4'd9, 2'd2, 2'd0, 0, 4'b0001, 4'b0100, "R5");
    step(1, 4'd3, 4'd3, 4'd1, 4'd1, 2'd0, 2'd1, 0, 4'b1100, 4'h0, "");
    step(1, 4'd3, 4'd3, 4'd1, 4'd1, 2'd0, 2'd1, 0, 4'b0101, 4'h0, "");
    step(1, 4'd3, 4'd3, 4'd1, 4'd1, 2'd0, 2'd1, 0, 4'b1001, 4'h0, "");
    step(1, 4'd3, 4'd3, 4'd1, 4'd1, 2'd3, 2'd1, 0, 4'h0, 4'b1010, "R8");
    step(1, 4'd3, 4'd3, 4'd1, 4'd1, 2'd3, 2'd1, 0, 4'h0, 4'b0010, "");
    // R9 empty vector, R7 forced direction ignores it
    step(1, 4'd3, 4'd3, 4'd1, 4'd1, 2'd0, 2'd3, 0, 4'h0, 4'hF, "R9");
    step(1, 4'd3, 4'd3, 4'd1, 4'd1, 2'd3, 2'd0, 0, 4'hF, 4'h0, "R9");
    step(1, 4'd3, 4'd3, 4'd1, 4'd1, 2'd1, 2'd2, 0, 4'b0100, 4'h0, "R7");
    // R2 hold while inputs change, R10 new vector seen at next head
    step(1, 4'd3, 4'd3, 4'd1, 4'd1, 2'd0, 2'd1, 0, 4'b0100, 4'h0, "R10");
    step(0, 4'd3, 4'd3, 4'd1, 4'd1, 2'd0, 2'd1, 0, 4'b0001, 4'h0, "");
    step(0, 4'd0, 4'd9, 4'd7, 4'd1, 2'd1, 2'd1, 1, 4'b1000, 4'hF, "");
    step(1, 4'd3, 4'd3, 4'd1, 4'd1, 2'd0, 2'd1, 0, 4'b0001, 4'h0, "R10");
    step(1, 4'd3, 4'd3, 4'd1, 4'd1, 2'd0, 2'd1, 0, 4'b1000, 4'h0, "R10");
    step(0, 4'd3, 4'd3, 4'd1, 4'd1, 2'd0, 2'd1, 0, 4'b0000, 4'h0, "");

    // mixed patterns
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r;
      r = $urandom;
      step((r[1:0] != 0), r[5:2], r[9:6], r[13:10], r[17:14], r[19:18], r[21:20],
           r[22] & r[23], r[27:24], r[31:28], "");
    end
    step(0, 4'd0, 4'd0, 4'd0, 4'd0, 2'd0, 2'd0, 0, 4'h0, 4'h0, "");
    @(negedge clk);
    check_all();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule